// File: doc/BRIEF.md
# Saturating Pipelined Data Register

This block is a clocked register for integer sample streams. A 32-bit signed word is captured on one chosen clock edge, either rising or falling. It moves through a pipeline whose depth is fixed at elaboration, and it appears at the output after that many capture edges. The word leaving the pipeline can be clamped to a narrower range. That range is either signed or unsigned, and its width is set by a bit-count parameter. With clamping off, the full 32-bit signed value reaches the output unchanged.

Typical uses are a one-sample memory inside a discrete-time integrator or accumulator, or a latency-matching delay in a fixed-point datapath. The clamp sets the output word width for the logic downstream.

There is no handshake. The block is a pure clocked delay, so a new input is taken on every capture edge and one result comes out per edge. All configuration is fixed at elaboration and cannot change at run time. The configuration covers the depth, the edge, whether clamping is on, the number type, the bit count and the reset value.

Top module: `satreg_top`

## Requirements
- R1: When LIMIT_EN is 0, `dout` equals the input value taken DEPTH capture edges earlier, for every 32-bit signed value, including -2^31 and 2^31-1.
- R2: With FALL_EDGE = 1, the pipeline and `dout` change only on falling edges of `clk`. With FALL_EDGE = 0, they change only on rising edges. Between capture edges, `dout` holds its value.
- R3: A sample on `din` at a capture edge reaches `dout` just after the DEPTH-th capture edge, counting that edge as the first. DEPTH = 0 behaves exactly like DEPTH = 1.
- R4: With LIMIT_EN = 1 and NUM_KIND = NUM_SIGNED, `dout` is always within -2^(BITS-1) .. 2^(BITS-1)-1. A value outside that range becomes the nearer bound.
- R5: With LIMIT_EN = 1 and NUM_KIND = NUM_UNSIGNED, a negative value becomes 0 and a value above 2^BITS-1 becomes 2^BITS-1. BITS is limited to 1..31.
- R6: `rst` is active-high and synchronous to the capture edge, and it loads every pipeline stage with INIT. After a capture edge with `rst` high, `dout` equals INIT clamped by the active limit mode. It keeps that value until fresh samples work through the pipeline.
- R7: In either limit mode, a value inside the allowed range reaches `dout` unchanged. Clamping is applied only to the value leaving the last stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; FALL_EDGE selects which edge captures |
| rst | input | 1 | Synchronous active-high reset, sampled on the capture edge |
| din | input | 32 | Signed input sample |
| dout | output | 32 | Signed delayed and optionally clamped sample |

## Verification
The hardest condition to reach is a reset that arrives while the pipeline still holds different samples near the clamp bounds. After that reset, the output must show the clamped initial value for exactly DEPTH edges and then resume the stream with the correct alignment. The stimulus fills the pipeline with values on both sides of each bound. It then pulses reset in the middle of the run and keeps driving right afterwards. A falling-edge instance is also sampled between the rising and falling edges. This exposes any update on the wrong edge, which would otherwise be hidden because the value settles before the later sample point.

// File: rtl/satreg_pkg.sv
package satreg_pkg;

  localparam int unsigned SAMPLE_W = 32;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  typedef enum logic {
    NUM_SIGNED   = 1'b0,
    NUM_UNSIGNED = 1'b1
  } num_kind_e;

  // upper and lower clamp bounds as 64-bit integers
  function automatic longint bound_hi(input bit lim_en, input num_kind_e kind, input int bits);
    if (!lim_en)                 return 64'sd2147483647;
    else if (kind == NUM_SIGNED) return (64'sd1 <<< (bits - 1)) - 64'sd1;
    else                         return (64'sd1 <<< bits) - 64'sd1;
  endfunction

  function automatic longint bound_lo(input bit lim_en, input num_kind_e kind, input int bits);
    if (!lim_en)                 return -64'sd2147483648;
    else if (kind == NUM_SIGNED) return -(64'sd1 <<< (bits - 1));
    else                         return 64'sd0;
  endfunction

  function automatic sample_t sat_value(input sample_t v, input bit lim_en,
                                        input num_kind_e kind, input int bits);
    longint wide;
    longint hi;
    longint lo;
    wide = longint'(v);
    hi   = bound_hi(lim_en, kind, bits);
    lo   = bound_lo(lim_en, kind, bits);
    if (wide > hi)      return sample_t'(hi);
    else if (wide < lo) return sample_t'(lo);
    else                return v;
  endfunction

endpackage

// File: rtl/satreg_delay_line.sv
module satreg_delay_line #(
  parameter int unsigned STAGES    = 1,
  parameter bit          FALL_EDGE = 1'b0,
  parameter int          INIT      = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  satreg_pkg::sample_t        d,
  output satreg_pkg::sample_t        q
);
  import satreg_pkg::*;

  localparam sample_t INIT_V = sample_t'(INIT);

  sample_t stg [STAGES];

  if (FALL_EDGE) begin : g_fall
    always_ff @(negedge clk) begin
      if (rst) begin
        for (int k = 0; k < int'(STAGES); k++) stg[k] <= INIT_V;
      end else begin
        stg[0] <= d;
        for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
      end
    end
  end else begin : g_rise
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < int'(STAGES); k++) stg[k] <= INIT_V;
      end else begin
        stg[0] <= d;
        for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[STAGES-1];

  // checker clock: positive on the capture edge
  logic chk_clk;
  assign chk_clk = clk ^ FALL_EDGE;

  // R3: the head stage takes the input of the previous capture edge
  assert_head_capture_R3: assert property (@(posedge chk_clk) disable iff (rst)
    !rst |=> stg[0] == $past(d));

  // R3: every later stage takes its predecessor's previous value
  for (genvar k = 1; k < int'(STAGES); k++) begin : g_shift_chk
    assert_stage_shift_R3: assert property (@(posedge chk_clk) disable iff (rst)
      !rst |=> stg[k] == $past(stg[k-1]));
  end

endmodule

// File: rtl/satreg_clamp.sv
module satreg_clamp #(
  parameter bit                    LIMIT_EN = 1'b0,
  parameter satreg_pkg::num_kind_e NUM_KIND = satreg_pkg::NUM_SIGNED,
  parameter int                    BITS     = 16
) (
  input  satreg_pkg::sample_t a,
  output satreg_pkg::sample_t y
);
  import satreg_pkg::*;

  localparam longint HI = bound_hi(LIMIT_EN, NUM_KIND, BITS);
  localparam longint LO = bound_lo(LIMIT_EN, NUM_KIND, BITS);

  if (!LIMIT_EN) begin : g_pass
    assign y = a;
  end else begin : g_limit
    longint a_w;
    logic   over;
    logic   under;
    always_comb begin
      a_w   = longint'(a);
      over  = a_w > HI;
      under = a_w < LO;
      if (over)       y = sample_t'(HI);
      else if (under) y = sample_t'(LO);
      else            y = a;
    end
  end

endmodule

// File: rtl/satreg_top.sv
module satreg_top #(
  parameter int unsigned           DEPTH     = 2,
  parameter bit                    FALL_EDGE = 1'b0,
  parameter bit                    LIMIT_EN  = 1'b0,
  parameter satreg_pkg::num_kind_e NUM_KIND  = satreg_pkg::NUM_SIGNED,
  parameter int                    BITS      = 16,
  parameter int                    INIT      = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic signed [31:0] din,
  output logic signed [31:0] dout
);
  import satreg_pkg::*;

  localparam int unsigned STAGES  = (DEPTH == 0) ? 1 : DEPTH;
  localparam longint      HI      = bound_hi(LIMIT_EN, NUM_KIND, BITS);
  localparam longint      LO      = bound_lo(LIMIT_EN, NUM_KIND, BITS);
  localparam sample_t     INIT_CL = sat_value(sample_t'(INIT), LIMIT_EN, NUM_KIND, BITS);

  sample_t tail;

  satreg_delay_line #(
    .STAGES    (STAGES),
    .FALL_EDGE (FALL_EDGE),
    .INIT      (INIT)
  ) u_line (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (tail)
  );

  satreg_clamp #(
    .LIMIT_EN (LIMIT_EN),
    .NUM_KIND (NUM_KIND),
    .BITS     (BITS)
  ) u_clamp (
    .a (tail),
    .y (dout)
  );

  // checkers, clocked on the capture edge
  logic chk_clk;
  assign chk_clk = clk ^ FALL_EDGE;

  logic rst_q = 1'b0;
  always @(posedge chk_clk) begin
    if (rst_q) begin
      assert_reset_load_R6: assert (dout == INIT_CL);
    end
    rst_q <= rst;
  end

  if (!LIMIT_EN) begin : g_chk_pass
    assert_passthru_R1: assert property (@(posedge chk_clk) disable iff (rst)
      dout == tail);
  end else begin : g_chk_lim
    assert_in_range_R7: assert property (@(posedge chk_clk) disable iff (rst)
      (longint'(tail) <= HI && longint'(tail) >= LO) |-> dout == tail);
    if (NUM_KIND == NUM_SIGNED) begin : g_s
      assert_signed_bounds_R4: assert property (@(posedge chk_clk) disable iff (rst)
        longint'(dout) <= HI && longint'(dout) >= LO);
    end else begin : g_u
      assert_unsigned_bounds_R5: assert property (@(posedge chk_clk) disable iff (rst)
        !dout[31] && longint'(dout) <= HI);
    end
  end

endmodule

// File: tb/satreg_top_tb_top.sv
`timescale 1ns/1ps
module satreg_top_tb_top;
  import satreg_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [31:0] din = '0;
  logic signed [31:0] dout_i, dout_u, dout_n;

  always #2.5 clk = ~clk;

  // signed clamp, rising, depth 3
  satreg_top #(.DEPTH(3), .FALL_EDGE(1'b0), .LIMIT_EN(1'b1), .NUM_KIND(NUM_SIGNED),
               .BITS(8), .INIT(-5))
    dut_i (.clk(clk), .rst(rst), .din(din), .dout(dout_i));
  // unsigned clamp, falling, depth 0
  satreg_top #(.DEPTH(0), .FALL_EDGE(1'b1), .LIMIT_EN(1'b1), .NUM_KIND(NUM_UNSIGNED),
               .BITS(10), .INIT(700))
    dut_u (.clk(clk), .rst(rst), .din(din), .dout(dout_u));
  // unlimited, rising, depth 2
  satreg_top #(.DEPTH(2), .FALL_EDGE(1'b0), .LIMIT_EN(1'b0), .NUM_KIND(NUM_SIGNED),
               .BITS(31), .INIT(12345))
    dut_n (.clk(clk), .rst(rst), .din(din), .dout(dout_n));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  function automatic longint ref_sat(longint v, bit en, bit uns, int b);
    longint lo, hi;
    if (!en) return v;
    lo = uns ? 0 : -(64'sd1 <<< (b - 1));
    hi = uns ? ((64'sd1 <<< b) - 1) : ((64'sd1 <<< (b - 1)) - 1);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // behavioural models: queues of pending samples
  longint q_i[$];
  longint q_u[$];
  longint q_n[$];

  always @(posedge clk) begin
    if (rst) begin
      q_i = {-5, -5, -5};
      q_n = {12345, 12345};
    end else begin
      q_i.push_back(longint'(din)); void'(q_i.pop_front());
      q_n.push_back(longint'(din)); void'(q_n.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst) q_u = {700};
    else begin
      q_u.push_back(longint'(din)); void'(q_u.pop_front());
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int rst_win = 0;

  task automatic cycle(logic signed [31:0] v, logic r);
    longint e;
    @(posedge clk);
    #1;
    din = v;
    rst = r;
    if (r) rst_win = 4; else if (rst_win > 0) rst_win--;
    #1;
    // before the falling edge: falling-edge instance must not have moved yet
    check("R2", longint'(dout_u), ref_sat(q_u[0], 1, 1, 10));
    #2;
    e = q_n[0];
    check(rst_win > 0 ? "R6" : "R1", longint'(dout_n), e);
    e = ref_sat(q_i[0], 1, 0, 8);
    check(rst_win > 0 ? "R6" : (e != q_i[0] ? "R4" : "R7"), longint'(dout_i), e);
    e = ref_sat(q_u[0], 1, 1, 10);
    check(rst_win > 0 ? "R6" : (e != q_u[0] ? "R5" : "R3"), longint'(dout_u), e);
  endtask

  function automatic logic signed [31:0] pick(int n);
    case (n)
      0: return 0;          1: return 127;        2: return 128;
      3: return -128;       4: return -129;       5: return 1023;
      6: return 1024;       7: return -1;         8: return 32'sh7fffffff;
      9: return 32'sh80000000; 10: return 55;     11: return -77;
      12: return 500;       13: return 126;       14: return -127;
      default: return 2;
    endcase
  endfunction

  initial begin
    rst = 1'b1;
    // reset state: several edges with reset held
    repeat (4) cycle(32'sd999, 1'b1);
    for (int n = 0; n < 16; n++) cycle(pick(n), 1'b0);
    for (int n = 0; n < 80; n++) begin
      logic signed [31:0] v;
      case ($urandom % 3)
        0: v = $signed($urandom);
        1: v = $signed(($urandom % 1400)) - 300;
        default: v = $signed(($urandom % 300)) - 150;
      endcase
      cycle(v, 1'b0);
    end
    // mid-stream reset with a full pipeline of boundary values
    cycle(32'sd1500, 1'b0);
    cycle(-32'sd1500, 1'b0);
    cycle(32'sd127, 1'b0);
    cycle(32'sd0, 1'b1);
    cycle(32'sd0, 1'b1);
    for (int n = 0; n < 16; n++) cycle(pick(15 - n), 1'b0);
    for (int n = 0; n < 40; n++) cycle($signed($urandom), 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule